// File: doc/BRIEF.md
# Multi-Mode Timer Waveform Generator

This block is the counting and waveform core of a timer. One counter serves four compare channels. A 3-bit mode select chooses among three families of behaviour: free-running frequency toggling, single-slope PWM and dual-slope (centre-aligned) PWM. Each mode sets its own counter TOP source, its own update points, where buffered compare values become active, and its own overflow event points.

Software-facing logic outside the block writes compare values into per-channel buffer registers. The core moves them into the active compare registers at update points. With circular mode enabled on a channel, the active and buffer values exchange at every update, so a channel can alternate between two duty values with no further writes.

Each channel output passes through a polarity stage, which acts in the PWM modes only. A pair-swap stage follows it. The dead-time stage that would normally sit in between is a plain wire. An overflow flag is high for exactly the cycles in which the counter sits at an event point of the selected mode.

Top module: `wavegen_timer`

## Requirements
- R1: Mode 3 is reserved. While it is selected the counter is forced to 0, the direction to up, every channel's waveform state to low, no overflow is flagged and all outputs are low (polarity does not apply).
- R2: In modes 0 (period toggle), 1 (compare-0 toggle) and 2 (single-slope PWM) the counter counts up by one per enabled cycle and wraps to 0 on the cycle after it equals TOP. TOP is the active compare value of channel 0 in mode 1 and `per_i` otherwise. With `en_i` low the counter and direction hold.
- R3: In modes 4 to 7 the counter counts up to TOP (`per_i`), then down to 0, then up again. `dir_o` is 0 while counting up and 1 while counting down, and it changes on the edge where TOP or 0 is reached.
- R4: `ovf_o` is high in an enabled cycle when the counter is at TOP in modes 0 to 2, at 0 in modes 4 and 5, at TOP or 0 in mode 6, and at TOP only in mode 7.
- R5: Update points are TOP in modes 0 to 2, zero in modes 4, 5 and 7, and both TOP and zero in mode 6. At an update each channel's buffer value becomes active on `cc_o` (channel n at bits n*8+7..n*8). A write through `cc_we_i`/`cc_wdata_i` loads the buffer one edge later, and it wins over any circular copy in the same cycle.
- R6: In modes 0 and 1 a compare match (counter equals the channel's active value in an enabled cycle) toggles the channel output on the next edge. Updates leave the output unchanged.
- R7: In mode 2 an update drives the waveform state to 1 and, if there is no update in the same cycle, a match drives it to 0. The output is the state with polarity bit 0, and its inverse with polarity bit 1.
- R8: In modes 4 to 7 a match drives the waveform state to the inverse of `dir_o`. The output is that state with polarity bit 0, and its inverse with polarity bit 1.
- R9: With `circ_i[n]` set, an update without a write to channel n moves the old active value of channel n into its buffer, so successive updates alternate two values on `cc_o`.
- R10: Swap bit k exchanges outputs k and k+2 at the output pins. It has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| mode_i | input | 3 | Waveform mode select |
| per_i | input | 8 | Period value (TOP except in mode 1) |
| cc_we_i | input | 4 | Per-channel buffer write strobes |
| cc_wdata_i | input | 32 | Buffer write data, channel n at bits n*8+7..n*8 |
| pol_i | input | 4 | Per-channel output polarity (PWM modes) |
| circ_i | input | 4 | Per-channel circular buffer enable |
| swap_i | input | 2 | Output pair swap enables |
| cnt_o | output | 8 | Counter value |
| dir_o | output | 1 | Count direction, 1 = down |
| ovf_o | output | 1 | Overflow event flag |
| cc_o | output | 32 | Active compare values |
| wo_o | output | 4 | Waveform outputs after polarity and swap |

## Verification
The bench sweeps every mode encoding with both polarities and compares the counter, direction, overflow flag, active compare values and outputs against an arithmetic model on every cycle. The corner cases it targets are these:
- A compare value of 0, which matches at the dual-slope turnaround and would leave a design that mishandles the bottom point stuck at the wrong level.
- A compare value equal to TOP, where a single-slope design that lets the match win over the update shows a short glitch instead of a full-high period.
- A compare value above TOP, which must never match.
- Mode 1, where TOP follows the buffered channel 0 value, and a design that takes TOP from the period exposes itself at once.
- Circular channels mixed with plain channels and a write in mid-run, where a swapped priority leaves stale buffer contents on later updates.
- Enable gaps and swap patterns, where an event during a stall or a mis-wired pair mismatches the model.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
  typedef enum logic [2:0] {
    MODE_TGL_PER = 3'd0,
    MODE_TGL_CC0 = 3'd1,
    MODE_SS_PWM  = 3'd2,
    MODE_HOLD    = 3'd3,
    MODE_DS_ZA   = 3'd4,
    MODE_DS_ZB   = 3'd5,
    MODE_DS_TZ   = 3'd6,
    MODE_DS_T    = 3'd7
  } wgt_mode_e;

  typedef enum logic [1:0] {
    KIND_TOGGLE,
    KIND_SSPWM,
    KIND_DUAL,
    KIND_OFF
  } wave_kind_e;

  function automatic wave_kind_e kind_of(wgt_mode_e m);
    case (m)
      MODE_TGL_PER, MODE_TGL_CC0: kind_of = KIND_TOGGLE;
      MODE_SS_PWM:                kind_of = KIND_SSPWM;
      MODE_HOLD:                  kind_of = KIND_OFF;
      default:                    kind_of = KIND_DUAL;
    endcase
  endfunction

  function automatic logic is_pwm(wgt_mode_e m);
    return (m == MODE_SS_PWM) || m[2];
  endfunction
endpackage

// File: rtl/wgt_counter.sv
module wgt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             dual_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             top_hit_o,
  output logic             zero_hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_top, at_zero, top_nz, run;

  assign at_top     = (cnt_o == top_i);
  assign at_zero    = (cnt_o == '0);
  assign top_nz     = (top_i != '0);
  assign run        = en_i && !hold_i;
  assign top_hit_o  = run && at_top;
  assign zero_hit_o = run && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dir_o <= 1'b0;
    end else if (hold_i) begin
      cnt_o <= '0;
      dir_o <= 1'b0;
    end else if (en_i) begin
      if (!dual_i) begin
        dir_o <= 1'b0;
        cnt_o <= at_top ? '0 : cnt_o + ONE;
      end else if (!dir_o) begin
        if (at_top) begin
          dir_o <= top_nz;
          cnt_o <= top_nz ? top_i - ONE : '0;
        end else begin
          cnt_o <= cnt_o + ONE;
        end
      end else begin
        if (at_zero) begin
          dir_o <= 1'b0;
          cnt_o <= top_nz ? ONE : '0;
        end else begin
          cnt_o <= cnt_o - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/wgt_cc_bank.sv
module wgt_cc_bank #(
  parameter int CNT_W = 8,
  parameter int N_CH  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  upd_i,
  input  logic [N_CH-1:0]       we_i,
  input  logic [N_CH*CNT_W-1:0] wdata_i,
  input  logic [N_CH-1:0]       circ_i,
  output logic [N_CH*CNT_W-1:0] act_o
);
  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic [CNT_W-1:0] buf_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        if (upd_i) act_q <= buf_q;
        // a fresh write beats the circular copy-back
        if (we_i[n])                  buf_q <= wdata_i[n*CNT_W +: CNT_W];
        else if (upd_i && circ_i[n])  buf_q <= act_q;
      end
    end

    assign act_o[n*CNT_W +: CNT_W] = act_q;
  end
endmodule

// File: rtl/wgt_wave_bank.sv
module wgt_wave_bank
  import wgt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hold_i,
  input  logic                  run_i,
  input  wave_kind_e            kind_i,
  input  logic                  upd_i,
  input  logic                  dir_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [N_CH*CNT_W-1:0] act_i,
  input  logic [N_CH-1:0]       pol_i,
  input  logic [N_CH/2-1:0]     swap_i,
  output logic [N_CH-1:0]       wo_o
);
  localparam int HALF = N_CH / 2;

  logic [N_CH-1:0] wave_q, level;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic match;
    assign match = run_i && (cnt_i == act_i[n*CNT_W +: CNT_W]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wave_q[n] <= 1'b0;
      end else if (hold_i) begin
        wave_q[n] <= 1'b0;
      end else begin
        case (kind_i)
          KIND_TOGGLE: if (match) wave_q[n] <= ~wave_q[n];
          KIND_SSPWM: begin
            if (upd_i)      wave_q[n] <= 1'b1;
            else if (match) wave_q[n] <= 1'b0;
          end
          KIND_DUAL:   if (match) wave_q[n] <= ~dir_i;
          default:     wave_q[n] <= 1'b0;
        endcase
      end
    end
  end

  assign level = wave_q ^ pol_i;

  // dead-time stage is a pass-through; swap follows it
  for (genvar k = 0; k < HALF; k++) begin : g_swap
    assign wo_o[k]        = swap_i[k] ? level[k+HALF] : level[k];
    assign wo_o[k+HALF]   = swap_i[k] ? level[k]      : level[k+HALF];
  end
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
  import wgt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [2:0]            mode_i,
  input  logic [CNT_W-1:0]      per_i,
  input  logic [N_CH-1:0]       cc_we_i,
  input  logic [N_CH*CNT_W-1:0] cc_wdata_i,
  input  logic [N_CH-1:0]       pol_i,
  input  logic [N_CH-1:0]       circ_i,
  input  logic [N_CH/2-1:0]     swap_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  dir_o,
  output logic                  ovf_o,
  output logic [N_CH*CNT_W-1:0] cc_o,
  output logic [N_CH-1:0]       wo_o
);
  wgt_mode_e        md;
  logic             hold, run, dual;
  logic [CNT_W-1:0] top_val;
  logic             top_hit, zero_hit, upd;
  logic [N_CH-1:0]  pol_eff;

  assign md      = wgt_mode_e'(mode_i);
  assign hold    = (md == MODE_HOLD);
  assign dual    = mode_i[2];
  assign run     = en_i && !hold;
  assign top_val = (md == MODE_TGL_CC0) ? cc_o[CNT_W-1:0] : per_i;
  assign pol_eff = is_pwm(md) ? pol_i : '0;

  always_comb begin
    case (md)
      MODE_TGL_PER, MODE_TGL_CC0, MODE_SS_PWM: begin
        upd   = top_hit;
        ovf_o = top_hit;
      end
      MODE_DS_ZA, MODE_DS_ZB: begin
        upd   = zero_hit;
        ovf_o = zero_hit;
      end
      MODE_DS_TZ: begin
        upd   = top_hit || zero_hit;
        ovf_o = top_hit || zero_hit;
      end
      MODE_DS_T: begin
        upd   = zero_hit;
        ovf_o = top_hit;
      end
      default: begin
        upd   = 1'b0;
        ovf_o = 1'b0;
      end
    endcase
  end

  wgt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .hold_i     (hold),
    .dual_i     (dual),
    .top_i      (top_val),
    .cnt_o      (cnt_o),
    .dir_o      (dir_o),
    .top_hit_o  (top_hit),
    .zero_hit_o (zero_hit)
  );

  wgt_cc_bank #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cc_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .we_i    (cc_we_i),
    .wdata_i (cc_wdata_i),
    .circ_i  (circ_i),
    .act_o   (cc_o)
  );

  wgt_wave_bank #(.CNT_W(CNT_W), .N_CH(N_CH)) u_wave_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .run_i  (run),
    .kind_i (kind_of(md)),
    .upd_i  (upd),
    .dir_i  (dir_o),
    .cnt_i  (cnt_o),
    .act_i  (cc_o),
    .pol_i  (pol_eff),
    .swap_i (swap_i),
    .wo_o   (wo_o)
  );
endmodule

// File: rtl/wavegen_timer_chk.sv
module wavegen_timer_chk #(
  parameter int CNT_W = 8,
  parameter int N_CH  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] per_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_o,
  input logic             ovf_o,
  input logic [N_CH-1:0]  wo_o
);
  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3) |=> (cnt_o == '0 && (mode_i != 3'd3 || (wo_o == '0 && !ovf_o))));

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (mode_i == 3'd0 || mode_i == 3'd2) && cnt_o == per_i) |=> (cnt_o == '0));

  a_r2_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && mode_i != 3'd3) |=> ($stable(cnt_o) && $stable(dir_o)));

  a_r3_turn_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i[2] && !dir_o && cnt_o == per_i && per_i != '0) |=> dir_o);

  a_r3_single_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[2] && (en_i || mode_i == 3'd3)) |=> !dir_o);

  a_r4_no_event_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3 || !en_i) |-> !ovf_o);

  a_r4_top_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && mode_i == 3'd7) |-> (cnt_o == per_i));

  a_r4_zero_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && (mode_i == 3'd4 || mode_i == 3'd5)) |-> (cnt_o == '0));
endmodule

bind wavegen_timer wavegen_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .mode_i (mode_i),
  .per_i  (per_i),
  .cnt_o  (cnt_o),
  .dir_o  (dir_o),
  .ovf_o  (ovf_o),
  .wo_o   (wo_o)
);

// File: tb/wavegen_timer_bench.sv
module wavegen_timer_bench;
  localparam int W = 8;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic [W-1:0] per_i = 8'd6;
  logic [N-1:0] cc_we_i = '0;
  logic [N*W-1:0] cc_wdata_i = '0;
  logic [N-1:0] pol_i = '0;
  logic [N-1:0] circ_i = '0;
  logic [1:0]   swap_i = '0;
  logic [W-1:0] cnt_o;
  logic         dir_o, ovf_o;
  logic [N*W-1:0] cc_o;
  logic [N-1:0] wo_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [W-1:0] m_cnt = '0;
  logic         m_dir = 1'b0;
  logic [N-1:0] m_r = '0;
  logic [W-1:0] m_act [N];
  logic [W-1:0] m_buf [N];

  always #10 clk_i = ~clk_i;

  wavegen_timer u_wavegen_timer (
    .clk_i, .rst_ni, .en_i, .mode_i, .per_i, .cc_we_i, .cc_wdata_i,
    .pol_i, .circ_i, .swap_i, .cnt_o, .dir_o, .ovf_o, .cc_o, .wo_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (mode %0d cnt %0d)", req, act, exp, mode_i, m_cnt);
    end
  endtask

  task automatic cycle();
    logic [W-1:0] top;
    logic run, th, zh, upd, ovf, dual, hold, pwm;
    logic [N-1:0] lvl, wo_e, mt, nr;
    logic [N*W-1:0] cc_e;
    string wtag;
    #1;
    hold = (mode_i == 3'd3);
    dual = mode_i[2];
    pwm  = (mode_i == 3'd2) || dual;
    top  = (mode_i == 3'd1) ? m_act[0] : per_i;
    run  = en_i && !hold;
    th   = run && (m_cnt == top);
    zh   = run && (m_cnt == 0);
    case (mode_i)
      3'd0, 3'd1, 3'd2: begin upd = th; ovf = th; end
      3'd4, 3'd5:       begin upd = zh; ovf = zh; end
      3'd6:             begin upd = th | zh; ovf = th | zh; end
      3'd7:             begin upd = zh; ovf = th; end
      default:          begin upd = 0; ovf = 0; end
    endcase
    lvl = m_r ^ (pwm ? pol_i : 4'b0);
    wo_e = lvl;
    for (int k = 0; k < 2; k++)
      if (swap_i[k]) begin wo_e[k] = lvl[k+2]; wo_e[k+2] = lvl[k]; end
    for (int n = 0; n < N; n++) cc_e[n*W +: W] = m_act[n];

    if (swap_i != 0)            wtag = "R10";
    else if (hold)              wtag = "R1";
    else if (mode_i < 3'd2)     wtag = "R6";
    else if (mode_i == 3'd2)    wtag = "R7";
    else                        wtag = "R8";
    check(hold ? "R1 cnt" : (dual ? "R3 cnt" : "R2 cnt"), 32'(cnt_o), 32'(m_cnt));
    check("R3 dir", 32'(dir_o), 32'(m_dir));
    check("R4 ovf", 32'(ovf_o), 32'(ovf));
    check(circ_i != 0 ? "R9 cc" : "R5 cc", cc_o, cc_e);
    check(wtag, 32'(wo_o), 32'(wo_e));

    // advance reference
    for (int n = 0; n < N; n++) mt[n] = run && (m_cnt == m_act[n]);
    nr = m_r;
    for (int n = 0; n < N; n++) begin
      if (hold) nr[n] = 0;
      else if (mode_i < 3'd2) begin if (mt[n]) nr[n] = ~m_r[n]; end
      else if (mode_i == 3'd2) begin
        if (upd) nr[n] = 1; else if (mt[n]) nr[n] = 0;
      end else if (mt[n]) nr[n] = ~m_dir;
    end
    for (int n = 0; n < N; n++) begin
      logic [W-1:0] a_old;
      a_old = m_act[n];
      if (upd) m_act[n] = m_buf[n];
      if (cc_we_i[n]) m_buf[n] = cc_wdata_i[n*W +: W];
      else if (upd && circ_i[n]) m_buf[n] = a_old;
    end
    m_r = nr;
    if (hold) begin m_cnt = 0; m_dir = 0; end
    else if (en_i) begin
      if (!dual) begin m_dir = 0; m_cnt = (m_cnt == top) ? 8'd0 : m_cnt + 8'd1; end
      else if (!m_dir) begin
        if (m_cnt == top) begin m_dir = (top != 0); m_cnt = (top != 0) ? top - 8'd1 : 8'd0; end
        else m_cnt = m_cnt + 8'd1;
      end else begin
        if (m_cnt == 0) begin m_dir = 0; m_cnt = (top != 0) ? 8'd1 : 8'd0; end
        else m_cnt = m_cnt - 8'd1;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_mode(logic [2:0] md, logic [3:0] pol, logic [3:0] circ,
                          logic [1:0] sw, int ncyc, logic [N*W-1:0] vals);
    mode_i = 3'd3; en_i = 1; pol_i = 0; circ_i = 0; swap_i = 0;
    cycle();
    cycle();
    cc_we_i = 4'hF; cc_wdata_i = vals;
    cycle();
    cc_we_i = 0;
    mode_i = md; pol_i = pol; circ_i = circ; swap_i = sw;
    for (int i = 0; i < ncyc; i++) begin
      en_i = (i % 9 != 8);
      if (i == 20) begin cc_we_i = 4'b0110; cc_wdata_i = {8'd1, 8'd5, 8'd3, 8'd4}; end
      else cc_we_i = 0;
      cycle();
    end
  endtask

  initial begin
    for (int n = 0; n < N; n++) begin m_act[n] = 0; m_buf[n] = 0; end
    repeat (3) @(negedge clk_i);
    check("reset cnt", 32'(cnt_o), 0);
    check("reset wo", 32'(wo_o), 0);
    check("reset cc", cc_o, 0);
    check("reset ovf", 32'(ovf_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    // values: ch3,ch2,ch1,ch0; zero, equal to TOP, above TOP
    for (int m = 0; m < 8; m++) begin
      run_mode(3'(m), 4'b0000, 0, 0, 40, {8'd6, 8'd2, 8'd0, 8'd4});
      run_mode(3'(m), 4'b1010, 0, 0, 40, {8'd9, 8'd6, 8'd1, 8'd3});
    end
    run_mode(3'd2, 4'b0000, 4'b0101, 0, 60, {8'd6, 8'd2, 8'd0, 8'd4});
    run_mode(3'd5, 4'b0011, 4'b1111, 0, 60, {8'd1, 8'd5, 8'd2, 8'd3});
    run_mode(3'd1, 4'b0000, 4'b0001, 0, 60, {8'd2, 8'd1, 8'd3, 8'd5});
    run_mode(3'd6, 4'b0000, 0, 2'b01, 40, {8'd6, 8'd2, 8'd0, 8'd4});
    run_mode(3'd0, 4'b0000, 0, 2'b11, 40, {8'd6, 8'd2, 8'd0, 8'd4});
    run_mode(3'd4, 4'b0001, 0, 2'b10, 40, {8'd1, 8'd5, 8'd2, 8'd3});
    run_mode(3'd7, 4'b1100, 4'b0010, 2'b11, 40, {8'd5, 8'd3, 8'd6, 8'd0});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule